// File: doc/BRIEF.md
# Output-Balanced Training Spike Generator

This block produces the stimulus used to train a two-input spiking logic gate. Each training group presents one two-bit operand pattern (A, B) to the input layer and one teacher spike to the output layer. Every operand is dual-rail coded, so exactly one of its two input neurons fires. The teacher spike goes to the output neuron that stands for the correct result of the selected gate. All spikes of a group fall in the group's first timestep, and a fixed number of idle timesteps follows. One timestep is one clock cycle.

Pattern choice is not uniform. For each group the generator first draws the wanted result (0 or 1) from a pseudo-random bit. It then draws one of the patterns that give that result under the selected gate. The two result classes therefore get about the same number of teacher/input spike pairs, including for gates whose truth table has three patterns of one result and one of the other. A start pulse latches the gate code and the seed. The run then emits a fixed number of groups that depends on the gate, raises a done flag and waits for the next start.

Top module: `balanced_spike_trainer`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge at which it was high, `in_spk`, `tch_spk`, `grp_vld` and `done` are all zero.
- R2: A start accepted while no run is active makes `grp_vld` high in the cycle that follows the sampling edge. Later groups begin every 5 cycles, and `grp_vld` is high for one cycle per group.
- R3: Input coding is dual-rail. `in_spk[0]` fires when A is 0 and `in_spk[1]` fires when A is 1. `in_spk[2]` fires when B is 0 and `in_spk[3]` fires when B is 1. Each operand pair has exactly one spike in a group's `grp_vld` cycle, and `in_spk` is zero in every other cycle.
- R4: Gate codes are 0 AND, 1 OR, 2 NAND, 3 NOR, 4 XOR and 5 XNOR. In the `grp_vld` cycle exactly one teacher line fires: `tch_spk[1]` when the latched gate gives 1 for the presented A, B, and `tch_spk[0]` when it gives 0. `tch_spk` is zero in all other cycles.
- R5: Over one run, between 40% and 60% of the groups have result 1, for every gate including the unbalanced ones (AND, OR, NAND, NOR).
- R6: Over one run, each of the four patterns 00, 01, 10 and 11 (A then B) is presented at least once.
- R7: A run has 1400 groups for codes 0 to 3 and 2000 groups for codes 4 and 5. `done` rises 5 cycles after the last `grp_vld` and stays high, with no further spikes, until a start is accepted.
- R8: During a run, `start` and any change of `gate_sel` have no effect on the group count or the teacher mapping. A start carrying code 6 or 7 is ignored at all times.
- R9: Two runs with the same gate and seed present the same pattern sequence. A seed of zero still gives a working, balanced run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one timestep |
| rst | input | 1 | Synchronous active-high reset |
| gate_sel | input | 3 | Gate code, latched at an accepted start |
| start | input | 1 | Begins a run when no run is active |
| seed | input | 16 | Pseudo-random seed, latched at an accepted start |
| in_spk | output | 4 | Dual-rail input spikes {B=1, B=0, A=1, A=0} |
| tch_spk | output | 2 | Teacher spikes {result 1, result 0} |
| grp_vld | output | 1 | High in the first timestep of each group |
| done | output | 1 | High after the run's last group until the next accepted start |

## Verification
The first group's spikes must appear in the cycle after the edge that samples `start`. Each later group follows exactly 5 cycles after the one before, and `done` appears 5 cycles after the final group. The bench drives every input at the falling edge and samples at the next falling edge, with a running counter of cycles since the last group, so each check lands in the cycle these counts predict. The teacher line is compared with a truth table written in the bench for the pattern actually seen on the input rails. Result balance and pattern coverage are tallied over whole runs.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    localparam int N_OPS = 2;
    localparam int RAILS = 2 * N_OPS;

    typedef enum logic [2:0] {
        GATE_AND  = 3'd0,
        GATE_OR   = 3'd1,
        GATE_NAND = 3'd2,
        GATE_NOR  = 3'd3,
        GATE_XOR  = 3'd4,
        GATE_XNOR = 3'd5
    } gate_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    // ops[0] is operand A, ops[1] is operand B
    typedef struct packed {
        logic [N_OPS-1:0] ops;
        logic             result;
    } group_t;

    function automatic logic gate_valid(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic gate_is_parity(input gate_e g);
        return (g == GATE_XOR) || (g == GATE_XNOR);
    endfunction

    function automatic logic gate_result(input gate_e g, input logic a, input logic b);
        logic r;
        case (g)
            GATE_AND:  r = a & b;
            GATE_OR:   r = a | b;
            GATE_NAND: r = ~(a & b);
            GATE_NOR:  r = ~(a | b);
            GATE_XOR:  r = a ^ b;
            GATE_XNOR: r = ~(a ^ b);
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    // Bit p set when pattern p (p[1]=A, p[0]=B) yields the wanted result
    function automatic logic [3:0] cand_mask(input gate_e g, input logic want);
        logic [3:0] m;
        for (int p = 0; p < 4; p++) begin
            m[p] = (gate_result(g, p[1], p[0]) == want);
        end
        return m;
    endfunction

    function automatic logic [2:0] mask_count(input logic [3:0] m);
        logic [2:0] c;
        c = '0;
        for (int p = 0; p < 4; p++) begin
            c = c + {2'b00, m[p]};
        end
        return c;
    endfunction

    // Position of the n-th set bit of m, counting from bit 0
    function automatic logic [1:0] nth_set(input logic [3:0] m, input logic [1:0] n);
        logic [1:0] pos;
        logic [1:0] seen;
        logic       found;
        pos   = '0;
        seen  = '0;
        found = 1'b0;
        for (int p = 0; p < 4; p++) begin
            if (m[p] && !found) begin
                if (seen == n) begin
                    pos   = 2'(p);
                    found = 1'b1;
                end
                seen = seen + 2'd1;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/tsg_lfsr.sv
module tsg_lfsr #(
    parameter int                 W    = 16,
    parameter logic [W-1:0]       TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         adv,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] SAFE_SEED = W'(1);

    logic [W-1:0] next_state;

    // Galois form, shifting towards bit 0
    always_comb begin
        next_state = state >> 1;
        if (state[0]) begin
            next_state = next_state ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SAFE_SEED;
        end else if (load) begin
            state <= (seed == '0) ? SAFE_SEED : seed;
        end else if (adv) begin
            state <= next_state;
        end
    end
endmodule

// File: rtl/tsg_sequencer.sv
module tsg_sequencer
    import tsg_pkg::*;
#(
    parameter int GROUP_STEPS   = 5,
    parameter int GROUPS_SKEWED = 1400,
    parameter int GROUPS_PARITY = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] gate_sel,
    output gate_e      cfg_gate,
    output logic       accept,
    output logic       grp_first,
    output logic       done
);
    localparam int MAX_GROUPS = (GROUPS_SKEWED > GROUPS_PARITY) ? GROUPS_SKEWED : GROUPS_PARITY;
    localparam int CNT_W      = $clog2(MAX_GROUPS + 1);
    localparam int STEP_W     = (GROUP_STEPS > 2) ? $clog2(GROUP_STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(GROUP_STEPS - 1);

    phase_e             phase_q;
    logic [STEP_W-1:0]  step_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   total;

    assign accept    = start && gate_valid(gate_sel) && (phase_q != PH_RUN);
    assign grp_first = (phase_q == PH_RUN) && (step_q == '0);
    assign done      = (phase_q == PH_DONE);

    always_comb begin
        total = gate_is_parity(cfg_gate) ? CNT_W'(GROUPS_PARITY) : CNT_W'(GROUPS_SKEWED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            step_q   <= '0;
            cnt_q    <= '0;
            cfg_gate <= GATE_AND;
        end else begin
            case (phase_q)
                PH_RUN: begin
                    if (step_q == '0) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                    if (step_q == LAST_STEP) begin
                        step_q <= '0;
                        if (cnt_q == total) begin
                            phase_q <= PH_DONE;
                        end
                    end else begin
                        step_q <= step_q + STEP_W'(1);
                    end
                end
                default: begin
                    if (accept) begin
                        phase_q  <= PH_RUN;
                        step_q   <= '0;
                        cnt_q    <= '0;
                        cfg_gate <= gate_e'(gate_sel);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tsg_picker.sv
module tsg_picker
    import tsg_pkg::*;
#(
    parameter int RND_W = 16,
    parameter int SEL_W = 8
) (
    input  gate_e            gate,
    input  logic [RND_W-1:0] rnd,
    output group_t           grp
);
    logic             want;
    logic [SEL_W-1:0] frac;
    logic [3:0]       mask;
    logic [2:0]       n_cand;
    logic [1:0]       idx;
    logic [1:0]       pat;

    always_comb begin
        want   = rnd[0];
        frac   = rnd[SEL_W:1] ^ rnd[RND_W-1 -: SEL_W];
        mask   = cand_mask(gate, want);
        n_cand = mask_count(mask);
        // scale a fraction of 2^SEL_W onto 0 .. n_cand-1
        idx    = 2'(({3'b000, frac} * {{SEL_W{1'b0}}, n_cand}) >> SEL_W);
        pat    = nth_set(mask, idx);
        grp.ops    = {pat[0], pat[1]};
        grp.result = want;
    end
endmodule

// File: rtl/tsg_encoder.sv
module tsg_encoder
    import tsg_pkg::*;
(
    input  logic             emit,
    input  group_t           grp,
    output logic [RAILS-1:0] in_spk,
    output logic [1:0]       tch_spk
);
    for (genvar i = 0; i < N_OPS; i++) begin : g_rail
        assign in_spk[2*i]     = emit & ~grp.ops[i];
        assign in_spk[2*i + 1] = emit &  grp.ops[i];
    end

    assign tch_spk[0] = emit & ~grp.result;
    assign tch_spk[1] = emit &  grp.result;
endmodule

// File: rtl/balanced_spike_trainer.sv
module balanced_spike_trainer
    import tsg_pkg::*;
#(
    parameter int                  LFSR_W        = 16,
    parameter logic [LFSR_W-1:0]   LFSR_TAPS     = 16'hB400,
    parameter int                  SEL_W         = 8,
    parameter int                  GROUP_STEPS   = 5,
    parameter int                  GROUPS_SKEWED = 1400,
    parameter int                  GROUPS_PARITY = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        gate_sel,
    input  logic              start,
    input  logic [LFSR_W-1:0] seed,
    output logic [RAILS-1:0]  in_spk,
    output logic [1:0]        tch_spk,
    output logic              grp_vld,
    output logic              done
);
    gate_e             cfg_gate;
    logic              accept;
    logic              grp_first;
    logic [LFSR_W-1:0] rnd;
    group_t            grp;

    tsg_sequencer #(
        .GROUP_STEPS  (GROUP_STEPS),
        .GROUPS_SKEWED(GROUPS_SKEWED),
        .GROUPS_PARITY(GROUPS_PARITY)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .gate_sel (gate_sel),
        .cfg_gate (cfg_gate),
        .accept   (accept),
        .grp_first(grp_first),
        .done     (done)
    );

    tsg_lfsr #(
        .W   (LFSR_W),
        .TAPS(LFSR_TAPS)
    ) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .seed (seed),
        .adv  (grp_first),
        .state(rnd)
    );

    tsg_picker #(
        .RND_W(LFSR_W),
        .SEL_W(SEL_W)
    ) u_pick (
        .gate(cfg_gate),
        .rnd (rnd),
        .grp (grp)
    );

    tsg_encoder u_enc (
        .emit   (grp_first),
        .grp    (grp),
        .in_spk (in_spk),
        .tch_spk(tch_spk)
    );

    assign grp_vld = grp_first;
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker
    import tsg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [3:0] in_spk,
    input logic [1:0] tch_spk,
    input logic       grp_vld,
    input logic       done,
    input logic [2:0] cfg_gate
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (in_spk == '0 && tch_spk == '0 && !grp_vld && !done)); // R1

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        grp_vld |=> !grp_vld); // R2

    AST_SPIKES_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
        (in_spk != '0 || tch_spk != '0) |-> grp_vld); // R3

    AST_RAIL_A_ONE: assert property (@(posedge clk) disable iff (rst)
        grp_vld |-> $countones(in_spk[1:0]) == 1); // R3

    AST_RAIL_B_ONE: assert property (@(posedge clk) disable iff (rst)
        grp_vld |-> $countones(in_spk[3:2]) == 1); // R3

    AST_TEACHER_ONE: assert property (@(posedge clk) disable iff (rst)
        grp_vld |-> $countones(tch_spk) == 1); // R4

    AST_TEACHER_TRUTH: assert property (@(posedge clk) disable iff (rst)
        grp_vld |-> tch_spk[1] == gate_result(gate_e'(cfg_gate), in_spk[1], in_spk[3])); // R4

    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (rst)
        done |-> !grp_vld); // R7

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R7
endmodule

bind balanced_spike_trainer tsg_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .in_spk  (in_spk),
    .tch_spk (tch_spk),
    .grp_vld (grp_vld),
    .done    (done),
    .cfg_gate(cfg_gate)
);

// File: tb/test_balanced_spike_trainer.sv
`timescale 1ns/1ps
module test_balanced_spike_trainer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  gate_sel = 3'd0;
    logic        start = 1'b0;
    logic [15:0] seed = 16'h0;
    logic [3:0]  in_spk;
    logic [1:0]  tch_spk;
    logic        grp_vld;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;
    logic [1:0] pat_log [32];
    logic [1:0] ref_log [32];

    always #5 clk = ~clk;

    balanced_spike_trainer i_balanced_spike_trainer (
        .clk     (clk),
        .rst     (rst),
        .gate_sel(gate_sel),
        .start   (start),
        .seed    (seed),
        .in_spk  (in_spk),
        .tch_spk (tch_spk),
        .grp_vld (grp_vld),
        .done    (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit ref_gate(input int g, input bit a, input bit b);
        case (g)
            0: return a && b;
            1: return a || b;
            2: return !(a && b);
            3: return !(a || b);
            4: return a != b;
            5: return a == b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_spk == 0 && tch_spk == 0, "R1", "spikes in reset", {tch_spk, in_spk}, 0);
        chk(!grp_vld && !done, "R1", "strobe/done in reset", {grp_vld, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!grp_vld && !done, "R1", "idle after reset", {grp_vld, done}, 0);
    endtask

    // One whole run, checking every cycle; optionally pokes start and gate_sel mid-run
    task automatic run_gate(input int g, input logic [15:0] s, input bit poke);
        int  groups = 0;
        int  ones = 0;
        int  since = 0;
        int  exp_groups;
        bit  finished = 0;
        bit  [3:0] seen = '0;
        exp_groups = (g >= 4) ? 2000 : 1400;
        gate_sel = 3'(g);
        seed = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(grp_vld == 1'b1, "R2", "first group one cycle after start", grp_vld, 1);
        for (int cyc = 0; cyc < 12000 && !finished; cyc++) begin
            start = 1'b0;
            if (grp_vld) begin
                bit a;
                bit b;
                bit r;
                if (groups > 0) chk(since == 5, "R2", "group spacing", since, 5);
                since = 0;
                groups++;
                chk($countones(in_spk[1:0]) == 1, "R3", "operand A rails", in_spk[1:0], 1);
                chk($countones(in_spk[3:2]) == 1, "R3", "operand B rails", in_spk[3:2], 1);
                a = in_spk[1];
                b = in_spk[3];
                r = ref_gate(g, a, b);
                seen[{a, b}] = 1'b1;
                chk(tch_spk == {r, !r}, "R4", $sformatf("teacher gate %0d pattern %0d%0d", g, a, b),
                    tch_spk, {r, !r});
                if (r) ones++;
                if (groups <= 32) pat_log[groups-1] = {a, b};
                if (poke && groups == 10) begin
                    gate_sel = 3'(g ^ 4);
                    start = 1'b1;
                end
            end else begin
                if (in_spk != 0 || tch_spk != 0)
                    chk(1'b0, "R3", "spike outside group", {tch_spk, in_spk}, 0);
            end
            if (done) begin
                chk(since == 5, "R7", "done delay after last group", since, 5);
                chk(!grp_vld, "R7", "no group while done", grp_vld, 0);
                finished = 1;
            end else begin
                since++;
                @(negedge clk);
            end
        end
        gate_sel = 3'(g);
        chk(finished, "R7", "run reached done", finished, 1);
        chk(groups == exp_groups, "R7", $sformatf("group count gate %0d", g), groups, exp_groups);
        chk(ones * 10 >= groups * 4 && ones * 10 <= groups * 6, "R5",
            $sformatf("result-1 share gate %0d (ones of groups %0d)", g, groups), ones, groups / 2);
        chk(seen == 4'hF, "R6", $sformatf("all patterns seen gate %0d", g), seen, 15);
        if (poke) chk(groups == exp_groups, "R8", "mid-run start/gate change ignored", groups, exp_groups);
    endtask

    task automatic t_bad_code();
        gate_sel = 3'd6;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        gate_sel = 3'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (grp_vld || !done)
                chk(1'b0, "R8", "invalid code started a run", {grp_vld, done}, 1);
            @(negedge clk);
        end
        chk(done && !grp_vld, "R8", "invalid codes ignored", {grp_vld, done}, 1);
        gate_sel = 3'd0;
    endtask

    task automatic t_seed_repeat();
        int diffs = 0;
        run_gate(0, 16'h1234, 0);
        for (int i = 0; i < 32; i++) ref_log[i] = pat_log[i];
        run_gate(2, 16'h9E37, 0);
        run_gate(0, 16'h1234, 0);
        for (int i = 0; i < 32; i++) if (ref_log[i] != pat_log[i]) diffs++;
        chk(diffs == 0, "R9", "same seed same patterns", diffs, 0);
    endtask

    task automatic t_reset_midrun();
        gate_sel = 3'd4;
        seed = 16'h00F1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (23) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(in_spk == 0 && tch_spk == 0 && !grp_vld && !done, "R1", "reset during run",
            {done, grp_vld, tch_spk, in_spk}, 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(!grp_vld && !done, "R1", "stays idle after reset", {grp_vld, done}, 0);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        run_gate(1, 16'hACE1, 0);
        t_bad_code();
        run_gate(3, 16'h0000, 0);   // R9 zero seed
        run_gate(4, 16'h5A5A, 0);
        run_gate(5, 16'h0BAD, 0);
        run_gate(0, 16'h7777, 1);   // R8 mid-run poke
        t_seed_repeat();
        t_reset_midrun();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule